// File: doc/BRIEF.md
# Banked Level-Sensitive Interrupt Controller

This block gathers 64 level-sensitive peripheral request lines, arranged as two 32-bit banks, plus eight local request lines. It masks each line with a per-source enable bit and drives a single active-high interrupt request towards the processor. Clearing a request is the job of the peripheral that raised it. Software sees three pending views. Two are the masked peripheral banks. The third is a "basic" word that joins the masked local lines with unmaskable summary bits and a copy bit taken from the peripheral banks.

Each of the three banks has an enable mask with two write ports. One port only sets bits and the other only clears them, and both ports read back the current mask. A read-only identification word returns the number of the most urgent pending source. It scans the basic word's low byte first, then peripheral bank 2, then bank 1, and picks the highest set bit in each. Software can therefore dispatch an interrupt with one read.

The register port has one cycle per access. `reg_word` is the word index, so the byte offset is 4 × `reg_word`. Reads are combinational. Writes take effect on the rising clock edge.

Top module: `irq_bank_ctrl`

## Requirements
- R1: After synchronous reset, all three enable masks read 0 and `irq` is low.
- R2: A write to set-word 0x10, 0x14 or 0x18 (bank 1, bank 2, basic) ORs the written ones into that bank's mask. Written zeros change nothing.
- R3: A write to clear-word 0x20, 0x24 or 0x28 (bank 1, bank 2, basic) clears every mask bit that is written as one. All other bits are kept.
- R4: For each bank, a read of its set-word and a read of its clear-word both return that bank's current enable mask.
- R5: The pending words at 0x00 (sources 0–31) and 0x04 (sources 32–63) read as the raw source lines ANDed with the bank's enable mask. Bit n of 0x04 is source 32+n.
- R6: Basic pending bits 0–7 (0x08) read as `local_src` ANDed with the basic mask. The basic mask is 8 bits wide, and written bits 8–31 read back as 0.
- R7: Basic bit 8 is the OR of the enabled bank-1 sources other than source 7. Bit 9 is the OR of the enabled bank-2 sources. Bit 10 is enabled source 7. Bits 11–31 read 0. The basic mask has no effect on bits 8–10.
- R8: `irq` is high exactly when a bank-1, bank-2 or basic bits 0–7 pending bit is set.
- R9: The identification word at 0x2C returns 64+i for the highest set bit i of basic bits 0–7. If those bits are all clear, it returns 32+i for the highest set bit of the bank-2 pending word. If that word is also clear, it returns i for the highest set bit of the bank-1 pending word.
- R10: When nothing is pending, the identification word reads 0xFFFFFFFF.
- R11: Writes to 0x00, 0x04, 0x08, 0x2C or any unlisted offset leave all masks unchanged. Unlisted offsets (for example 0x0C, 0x1C, 0x40) read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the addressed word |
| reg_word | input | 6 | Word index (byte offset / 4) |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Combinational read data for `reg_word` |
| gpu_src | input | 64 | Level-sensitive peripheral request lines, sources 0–63 |
| local_src | input | 8 | Level-sensitive local request lines, sources 64–71 |
| irq | output | 1 | Active-high interrupt request |

## Verification
The only state in this block is the three enable masks. A corrupted mask bit therefore shows at the ports in the same cycle: as a wrong readback at both the set-word and the clear-word, as a pending bit that is present or missing for a held source, and through `irq` and the identification word. A wrong scan order or a wrong bank base shows up only when several banks are pending at once. For that reason the stimulus keeps sources in all three banks active together and then removes them one bank at a time. Mistakes in the summary and copy bits show up when the copied source is masked while its neighbours remain pending.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int DW      = 32;
    localparam int GPU_N   = 64;
    localparam int LOCAL_N = 8;
    localparam int NBANK   = 3;
    localparam int COPY_SRC = 7;
    localparam int IDX_W   = $clog2(DW);

    // word indices (byte offset / 4)
    localparam logic [5:0] W_PEND1 = 6'h00;
    localparam logic [5:0] W_PEND2 = 6'h01;
    localparam logic [5:0] W_PENDB = 6'h02;
    localparam logic [5:0] W_SET1  = 6'h04;
    localparam logic [5:0] W_SET2  = 6'h05;
    localparam logic [5:0] W_SETB  = 6'h06;
    localparam logic [5:0] W_CLR1  = 6'h08;
    localparam logic [5:0] W_CLR2  = 6'h09;
    localparam logic [5:0] W_CLRB  = 6'h0A;
    localparam logic [5:0] W_SRC   = 6'h0B;

    typedef enum logic [2:0] {K_NONE, K_PEND, K_SET, K_CLR, K_SRC} kind_e;

    typedef struct packed {
        kind_e      kind;
        logic [1:0] bank;   // 0 = bank 1, 1 = bank 2, 2 = basic
    } dec_t;

    typedef struct packed {
        logic             found;
        logic [IDX_W-1:0] idx;
    } hit_t;

    function automatic dec_t decode(logic [5:0] w);
        dec_t d;
        d.kind = K_NONE;
        d.bank = 2'd0;
        case (w)
            W_PEND1: begin d.kind = K_PEND; d.bank = 2'd0; end
            W_PEND2: begin d.kind = K_PEND; d.bank = 2'd1; end
            W_PENDB: begin d.kind = K_PEND; d.bank = 2'd2; end
            W_SET1:  begin d.kind = K_SET;  d.bank = 2'd0; end
            W_SET2:  begin d.kind = K_SET;  d.bank = 2'd1; end
            W_SETB:  begin d.kind = K_SET;  d.bank = 2'd2; end
            W_CLR1:  begin d.kind = K_CLR;  d.bank = 2'd0; end
            W_CLR2:  begin d.kind = K_CLR;  d.bank = 2'd1; end
            W_CLRB:  begin d.kind = K_CLR;  d.bank = 2'd2; end
            W_SRC:   begin d.kind = K_SRC;  d.bank = 2'd0; end
            default: ;
        endcase
        return d;
    endfunction

    // highest set bit of a word
    function automatic hit_t msb_hit(logic [DW-1:0] v);
        hit_t h;
        h.found = 1'b0;
        h.idx   = '0;
        for (int i = 0; i < DW; i++) begin
            if (v[i]) begin
                h.found = 1'b1;
                h.idx   = IDX_W'(i);
            end
        end
        return h;
    endfunction

endpackage

// File: rtl/irqc_en_bank.sv
module irqc_en_bank #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         set_stb,
    input  logic         clr_stb,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] mask
);
    logic [W-1:0] set_bits;
    logic [W-1:0] clr_bits;

    always_comb begin
        set_bits = set_stb ? wdata : '0;
        clr_bits = clr_stb ? wdata : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) mask <= '0;
        else     mask <= (mask | set_bits) & ~clr_bits;
    end
endmodule

// File: rtl/irqc_basic_build.sv
module irqc_basic_build
    import irqc_pkg::*;
(
    input  logic [GPU_N-1:0]   gpu_pend,
    input  logic [LOCAL_N-1:0] local_pend,
    output logic [DW-1:0]      basic
);
    localparam logic [DW-1:0] SUM1_MASK = ~(DW'(1) << COPY_SRC);
    localparam int USED = LOCAL_N + 3;

    logic sum1, sum2, copy_bit;

    always_comb begin
        sum1     = |(gpu_pend[DW-1:0] & SUM1_MASK);
        sum2     = |gpu_pend[GPU_N-1:DW];
        copy_bit = gpu_pend[COPY_SRC];
        basic    = {{(DW-USED){1'b0}}, copy_bit, sum2, sum1, local_pend};
    end
endmodule

// File: rtl/irqc_src_scan.sv
module irqc_src_scan
    import irqc_pkg::*;
(
    input  logic [LOCAL_N-1:0] basic_lo,
    input  logic [DW-1:0]      pend2,
    input  logic [DW-1:0]      pend1,
    output logic [DW-1:0]      src_num
);
    hit_t hb, h2, h1;

    always_comb begin
        hb = msb_hit(DW'(basic_lo));
        h2 = msb_hit(pend2);
        h1 = msb_hit(pend1);
        if (hb.found)      src_num = {{(DW-IDX_W-2){1'b0}}, 2'b10, hb.idx};
        else if (h2.found) src_num = {{(DW-IDX_W-2){1'b0}}, 2'b01, h2.idx};
        else if (h1.found) src_num = {{(DW-IDX_W-2){1'b0}}, 2'b00, h1.idx};
        else               src_num = '1;
    end
endmodule

// File: rtl/irq_bank_ctrl.sv
module irq_bank_ctrl
    import irqc_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [5:0]         reg_word,
    input  logic [DW-1:0]      wr_data,
    output logic [DW-1:0]      rd_data,
    input  logic [GPU_N-1:0]   gpu_src,
    input  logic [LOCAL_N-1:0] local_src,
    output logic               irq
);
    dec_t          dec;
    logic [DW-1:0] en_q [NBANK];
    logic [DW-1:0] pend1, pend2, basic;
    logic [DW-1:0] src_num;

    assign dec = decode(reg_word);

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        localparam int BW = (b == NBANK - 1) ? LOCAL_N : DW;
        logic [BW-1:0] m;
        irqc_en_bank #(.W(BW)) u_en (
            .clk     (clk),
            .rst     (rst),
            .set_stb (wr_en && dec.kind == K_SET && dec.bank == 2'(b)),
            .clr_stb (wr_en && dec.kind == K_CLR && dec.bank == 2'(b)),
            .wdata   (wr_data[BW-1:0]),
            .mask    (m)
        );
        assign en_q[b] = DW'(m);
    end

    assign pend1 = gpu_src[DW-1:0]     & en_q[0];
    assign pend2 = gpu_src[GPU_N-1:DW] & en_q[1];

    irqc_basic_build u_basic (
        .gpu_pend   ({pend2, pend1}),
        .local_pend (local_src & en_q[2][LOCAL_N-1:0]),
        .basic      (basic)
    );

    irqc_src_scan u_scan (
        .basic_lo (basic[LOCAL_N-1:0]),
        .pend2    (pend2),
        .pend1    (pend1),
        .src_num  (src_num)
    );

    assign irq = (|pend1) | (|pend2) | (|basic[LOCAL_N-1:0]);

    always_comb begin
        rd_data = '0;
        case (dec.kind)
            K_PEND: begin
                case (dec.bank)
                    2'd0:    rd_data = pend1;
                    2'd1:    rd_data = pend2;
                    default: rd_data = basic;
                endcase
            end
            K_SET, K_CLR: begin
                case (dec.bank)
                    2'd0:    rd_data = en_q[0];
                    2'd1:    rd_data = en_q[1];
                    default: rd_data = en_q[2];
                endcase
            end
            K_SRC:   rd_data = src_num;
            default: rd_data = '0;
        endcase
    end
endmodule

// File: rtl/irq_bank_ctrl_chk.sv
module irq_bank_ctrl_chk
    import irqc_pkg::*;
(
    input logic          clk,
    input logic          rst,
    input logic          wr_en,
    input logic [5:0]    reg_word,
    input logic [DW-1:0] wr_data,
    input logic [DW-1:0] en1,
    input logic [DW-1:0] en2,
    input logic [DW-1:0] enb,
    input logic [DW-1:0] src_num,
    input logic          irq
);
    logic mask_word;
    assign mask_word = (reg_word == W_SET1) || (reg_word == W_SET2) || (reg_word == W_SETB) ||
                       (reg_word == W_CLR1) || (reg_word == W_CLR2) || (reg_word == W_CLRB);

    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!irq && en1 == '0 && en2 == '0 && enb == '0));

    // R2
    set_or_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && reg_word == W_SET1) |=> (en1 == ($past(en1) | $past(wr_data))));

    // R3
    clr_bic_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && reg_word == W_CLR2) |=> (en2 == ($past(en2) & ~$past(wr_data))));

    // R8
    irq_vs_src_chk: assert property (@(posedge clk) disable iff (rst)
        irq == (src_num != '1));

    // R11
    ignored_write_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !mask_word) |=> ($stable(en1) && $stable(en2) && $stable(enb)));
endmodule

bind irq_bank_ctrl irq_bank_ctrl_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .reg_word (reg_word),
    .wr_data  (wr_data),
    .en1      (en_q[0]),
    .en2      (en_q[1]),
    .enb      (en_q[2]),
    .src_num  (src_num),
    .irq      (irq)
);

// File: tb/irq_bank_ctrl_tb.sv
module irq_bank_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [5:0]  reg_word = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic [63:0] gpu_src = '0;
    logic [7:0]  local_src = '0;
    logic        irq;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;   // 125 MHz

    irq_bank_ctrl u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .reg_word(reg_word),
        .wr_data(wr_data), .rd_data(rd_data), .gpu_src(gpu_src),
        .local_src(local_src), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %08h expected %08h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] off, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; reg_word = off[7:2]; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] off, output logic [31:0] d);
        @(negedge clk);
        reg_word = off[7:2];
        #1 d = rd_data;
    endtask

    task automatic chk_reg(input string tag, input logic [7:0] off, input logic [31:0] exp);
        logic [31:0] v;
        rd(off, v);
        chk(tag, v, exp);
    endtask

    task automatic chk_irq(input string tag, input logic exp);
        @(negedge clk);
        #1 chk(tag, {31'b0, irq}, {31'b0, exp});
    endtask

    task automatic t_reset;
        chk_reg("R1 en1", 8'h10, 32'h0);
        chk_reg("R1 en2", 8'h14, 32'h0);
        chk_reg("R1 enb", 8'h18, 32'h0);
        chk_irq("R1 irq", 1'b0);
        chk_reg("R10 idle src", 8'h2C, 32'hFFFF_FFFF);
    endtask

    task automatic t_set_clear;
        wr(8'h10, 32'h0000_00F0);
        wr(8'h10, 32'h0000_000F);
        chk_reg("R2 or", 8'h10, 32'h0000_00FF);
        wr(8'h10, 32'h0);
        chk_reg("R2 zeros", 8'h10, 32'h0000_00FF);
        chk_reg("R4 clr-word read", 8'h20, 32'h0000_00FF);
        wr(8'h20, 32'h0000_0030);
        chk_reg("R3 bic", 8'h10, 32'h0000_00CF);
        chk_reg("R4 after bic", 8'h20, 32'h0000_00CF);
        wr(8'h14, 32'h0000_0300);
        chk_reg("R4 bank2", 8'h24, 32'h0000_0300);
    endtask

    task automatic t_pending;
        gpu_src   = 64'h0000_0100_0000_00C5;
        local_src = 8'hA5;
        chk_reg("R5 pend1", 8'h00, 32'h0000_00C5);
        chk_reg("R5 pend2", 8'h04, 32'h0000_0100);
        wr(8'h18, 32'hFFFF_FF0F);
        chk_reg("R6 basic mask width", 8'h18, 32'h0000_000F);
        chk_reg("R6 R7 basic", 8'h08, 32'h0000_0705);
        chk_reg("R9 basic first", 8'h2C, 32'd66);
        chk_irq("R8 irq on", 1'b1);
    endtask

    task automatic t_order;
        wr(8'h28, 32'h0000_00FF);
        chk_reg("R7 unmaskable", 8'h08, 32'h0000_0700);
        chk_reg("R9 bank2 next", 8'h2C, 32'd40);
        wr(8'h24, 32'hFFFF_FFFF);
        chk_reg("R7 sum2 gone", 8'h08, 32'h0000_0500);
        chk_reg("R9 bank1 last", 8'h2C, 32'd7);
        wr(8'h20, 32'h0000_0080);
        chk_reg("R7 copy masked", 8'h08, 32'h0000_0100);
        chk_reg("R9 next bit", 8'h2C, 32'd6);
        wr(8'h20, 32'hFFFF_FFFF);
        chk_irq("R8 irq off", 1'b0);
        chk_reg("R10 none", 8'h2C, 32'hFFFF_FFFF);
        chk_reg("R7 basic clear", 8'h08, 32'h0);
        local_src = 8'h01;
        wr(8'h18, 32'h0000_0001);
        chk_irq("R8 local irq", 1'b1);
        chk_reg("R9 local src", 8'h2C, 32'd64);
    endtask

    task automatic t_ignored;
        wr(8'h10, 32'h0000_1234);
        wr(8'h00, 32'hFFFF_FFFF);
        wr(8'h08, 32'hFFFF_FFFF);
        wr(8'h2C, 32'hFFFF_FFFF);
        wr(8'h0C, 32'hFFFF_FFFF);
        wr(8'h40, 32'hFFFF_FFFF);
        chk_reg("R11 en1 kept", 8'h10, 32'h0000_1234);
        chk_reg("R11 en2 kept", 8'h14, 32'h0);
        chk_reg("R11 enb kept", 8'h18, 32'h0000_0001);
        chk_reg("R11 rsvd 0C", 8'h0C, 32'h0);
        chk_reg("R11 rsvd 1C", 8'h1C, 32'h0);
        chk_reg("R11 rsvd 40", 8'h40, 32'h0);
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_set_clear();
        t_pending();
        t_order();
        t_ignored();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule